// File: doc/BRIEF.md
# NaN Format Converter

This unit converts a NaN encoded in one binary floating-point width (half, single or double) into a NaN of another width. Each strobed request carries a source word, a source-width code and a destination-width code. The unit sorts the source into quiet or signaling. It carries the sign and the fraction through a 64-bit payload aligned to the most significant bit. It then rebuilds the NaN in the destination width, keeping the upper payload bits.

The destination NaN is replaced by the default NaN in two cases: a default-NaN mode input is asserted, or the payload bits that survive truncation are all zero. A signaling source raises an invalid indication for that request. The same indication is also ORed into a sticky exception bit, which is cleared by a separate input. Parameters choose how the quiet bit is read (standard or inverted), whether signaling NaNs exist at all, and the sign of the default NaN. Only NaN inputs are in scope. The result for an ordinary number is unspecified.

Top module: `nan_fmt_conv`

## Requirements
- R1: After reset, `out_valid`, `dst_word` and `invalid_sticky` are 0. A request strobed with `in_valid` at a clock edge appears on `dst_word`/`op_invalid` with `out_valid` high one cycle later. Without a strobe, `out_valid` is low and `dst_word` holds its last value.
- R2: Width codes are 0 = half (bits 15:0), 1 = single (bits 31:0), 2 or 3 = double (bits 63:0). Source bits above the selected width are ignored. The result is zero-extended above the destination width.
- R3: Under the standard convention, a NaN is quiet when its top fraction bit is 1. It is signaling when the top fraction bit is 0 and the rest of the fraction is nonzero.
- R4: `op_invalid` is 1 exactly when the source is signaling. This holds in default-NaN mode as well.
- R5: The result keeps the source sign, has an all-ones exponent, and has a fraction equal to the source fraction left-aligned in 64 bits. That fraction is zero-padded on widening and keeps its upper bits on narrowing. Converting does not quieten a NaN.
- R6: If the destination fraction taken from the payload is all zero, the default NaN is produced.
- R7: With `dflt_mode` high, the result is always the default NaN of the destination width.
- R8: When the source and destination codes are equal and `dflt_mode` is low, the source word passes through unchanged, including signaling NaNs.
- R9: `invalid_sticky` ORs in every `op_invalid`. `flag_clear` clears it at the next edge, but an invalid request at that same edge leaves it set.
- R10: The default NaNs with `DNAN_NEG=0` are 0x7E00, 0x7FC00000 and 0x7FF8000000000000. With `DNAN_NEG=1` they are 0xFE00, 0xFFC00000 and 0xFFF8000000000000.
- R11: With `QBIT_INVERTED=1`, the quiet and signaling tests are swapped: top fraction bit 1 means signaling. The default NaNs are then 0x7DFF, 0x7FBFFFFF and 0x7FF7FFFFFFFFFFFF.
- R12: With `ALL_QUIET=1`, no source is ever signaling, so `op_invalid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_word | input | 64 | Source NaN, right-aligned |
| src_fmt | input | 2 | Source width code |
| dst_fmt | input | 2 | Destination width code |
| dflt_mode | input | 1 | Force default NaN output |
| flag_clear | input | 1 | Clear the sticky invalid bit |
| out_valid | output | 1 | Result valid |
| dst_word | output | 64 | Destination NaN, zero-extended |
| op_invalid | output | 1 | Invalid for the current result |
| invalid_sticky | output | 1 | Accumulated invalid status |

## Verification
Each width pair is exercised in both the widening and the narrowing direction. Quiet and signaling sources are used, with both signs and with irregular payloads. This shows that the payload is aligned at the top and truncated from the bottom, rather than shifted from the bottom. Narrowing signaling NaNs whose only set bits fall below the destination fraction separate the zero-payload fallback from ordinary truncation. Same-width requests with signaling sources separate pass-through from conversion. Extra instances with the inverted, all-quiet and negative-default parameters apply the same words to show that classification and default encodings follow the parameters.

// File: rtl/nan_fmt_conv.sv
module nan_fmt_conv #(
  parameter bit QBIT_INVERTED = 1'b0,
  parameter bit ALL_QUIET     = 1'b0,
  parameter bit DNAN_NEG      = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] src_word,
  input  logic [1:0]  src_fmt,
  input  logic [1:0]  dst_fmt,
  input  logic        dflt_mode,
  input  logic        flag_clear,
  output logic        out_valid,
  output logic [63:0] dst_word,
  output logic        op_invalid,
  output logic        invalid_sticky
);

  logic [63:0] payload, built, dnan, passthru, result;
  logic        sign, exp_ones, std_quiet, std_sig, is_sig, trunc_zero;

  always_comb begin
    case (src_fmt)
      2'd0: begin
        payload  = {src_word[9:0], 54'b0};
        sign     = src_word[15];
        exp_ones = &src_word[14:10];
        passthru = {48'b0, src_word[15:0]};
      end
      2'd1: begin
        payload  = {src_word[22:0], 41'b0};
        sign     = src_word[31];
        exp_ones = &src_word[30:23];
        passthru = {32'b0, src_word[31:0]};
      end
      default: begin
        payload  = {src_word[51:0], 12'b0};
        sign     = src_word[63];
        exp_ones = &src_word[62:52];
        passthru = src_word;
      end
    endcase
  end

  assign std_quiet = exp_ones & payload[63];
  assign std_sig   = exp_ones & ~payload[63] & (|payload[62:0]);
  assign is_sig    = ALL_QUIET ? 1'b0 : (QBIT_INVERTED ? std_quiet : std_sig);

  always_comb begin
    case (dst_fmt)
      2'd0: begin
        built      = {48'b0, sign, 5'h1F, payload[63:54]};
        trunc_zero = ~|payload[63:54];
        dnan       = QBIT_INVERTED ? 64'h7DFF : (DNAN_NEG ? 64'hFE00 : 64'h7E00);
      end
      2'd1: begin
        built      = {32'b0, sign, 8'hFF, payload[63:41]};
        trunc_zero = ~|payload[63:41];
        dnan       = QBIT_INVERTED ? 64'h7FBF_FFFF :
                     (DNAN_NEG ? 64'hFFC0_0000 : 64'h7FC0_0000);
      end
      default: begin
        built      = {sign, 11'h7FF, payload[63:12]};
        trunc_zero = ~|payload[63:12];
        dnan       = QBIT_INVERTED ? 64'h7FF7_FFFF_FFFF_FFFF :
                     (DNAN_NEG ? 64'hFFF8_0000_0000_0000 : 64'h7FF8_0000_0000_0000);
      end
    endcase
  end

  assign result = dflt_mode            ? dnan :
                  (src_fmt == dst_fmt) ? passthru :
                  trunc_zero           ? dnan : built;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      dst_word       <= '0;
      op_invalid     <= 1'b0;
      invalid_sticky <= 1'b0;
    end else begin
      out_valid      <= in_valid;
      invalid_sticky <= (invalid_sticky & ~flag_clear) | (in_valid & is_sig);
      if (in_valid) begin
        dst_word   <= result;
        op_invalid <= is_sig;
      end
    end
  end

endmodule

// File: rtl/nan_fmt_conv_chk.sv
module nan_fmt_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  dst_fmt,
  input logic        flag_clear,
  input logic        out_valid,
  input logic [63:0] dst_word,
  input logic        op_invalid,
  input logic        invalid_sticky
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst_word));
  p_half_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_fmt == 2'd0) |=> (dst_word[63:16] == '0 && dst_word[14:10] == 5'h1F));
  p_single_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_fmt == 2'd1) |=> (dst_word[63:32] == '0 && dst_word[30:23] == 8'hFF));
  p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_invalid) |-> invalid_sticky);
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid_sticky && !flag_clear) |=> invalid_sticky);

endmodule

bind nan_fmt_conv nan_fmt_conv_chk u_chk (.*);

// File: tb/tb_nan_fmt_conv.sv
`timescale 1ns/1ps
module tb_nan_fmt_conv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src_word = '0;
  logic [1:0]  src_fmt = '0, dst_fmt = '0;
  logic        dflt_mode = 1'b0, flag_clear = 1'b0;
  logic        out_valid, op_invalid, invalid_sticky;
  logic [63:0] dst_word;
  logic        v_inv, v_aq, v_neg, s_inv, s_aq, s_neg, i_inv, i_aq, i_neg;
  logic [63:0] w_inv, w_aq, w_neg;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nan_fmt_conv dut (.clk, .rst_n, .in_valid, .src_word, .src_fmt, .dst_fmt,
    .dflt_mode, .flag_clear, .out_valid, .dst_word, .op_invalid, .invalid_sticky);
  nan_fmt_conv #(.QBIT_INVERTED(1'b1)) dut_inv (.clk, .rst_n, .in_valid, .src_word,
    .src_fmt, .dst_fmt, .dflt_mode, .flag_clear, .out_valid(v_inv), .dst_word(w_inv),
    .op_invalid(i_inv), .invalid_sticky(s_inv));
  nan_fmt_conv #(.ALL_QUIET(1'b1)) dut_aq (.clk, .rst_n, .in_valid, .src_word,
    .src_fmt, .dst_fmt, .dflt_mode, .flag_clear, .out_valid(v_aq), .dst_word(w_aq),
    .op_invalid(i_aq), .invalid_sticky(s_aq));
  nan_fmt_conv #(.DNAN_NEG(1'b1)) dut_neg (.clk, .rst_n, .in_valid, .src_word,
    .src_fmt, .dst_fmt, .dflt_mode, .flag_clear, .out_valid(v_neg), .dst_word(w_neg),
    .op_invalid(i_neg), .invalid_sticky(s_neg));

  // {src_fmt, dst_fmt, dflt, src, expected, expected invalid}
  localparam int NV = 15;
  localparam logic [133:0] VEC [NV] = '{
    {2'd0, 2'd1, 1'b0, 64'h7E01,               64'h7FC0_2000,           1'b0}, // R5 widen
    {2'd0, 2'd2, 1'b0, 64'hFC01,               64'hFFF0_0400_0000_0000, 1'b1}, // R5 R4
    {2'd1, 2'd0, 1'b0, 64'hFFE1_2345,          64'hFF09,                1'b0}, // R5 narrow
    {2'd1, 2'd0, 1'b0, 64'h7F80_0001,          64'h7E00,                1'b1}, // R6
    {2'd1, 2'd2, 1'b0, 64'h7FA0_0000,          64'h7FF4_0000_0000_0000, 1'b1}, // R3 R5
    {2'd2, 2'd1, 1'b0, 64'h7FF8_0000_0000_0ABC, 64'h7FC0_0000,          1'b0}, // R5
    {2'd2, 2'd0, 1'b0, 64'hFFF1_2345_6789_ABCD, 64'hFC48,               1'b1}, // R5 R3
    {2'd2, 2'd2, 1'b0, 64'h7FF0_0000_0000_0001, 64'h7FF0_0000_0000_0001, 1'b1}, // R8
    {2'd0, 2'd0, 1'b0, 64'h7D55,               64'h7D55,                1'b1}, // R8
    {2'd1, 2'd2, 1'b1, 64'h7FC1_2345,          64'h7FF8_0000_0000_0000, 1'b0}, // R7
    {2'd0, 2'd0, 1'b1, 64'h7C01,               64'h7E00,                1'b1}, // R7 R4
    {2'd2, 2'd1, 1'b0, 64'hFFF0_0000_0000_0001, 64'h7FC0_0000,          1'b1}, // R6
    {2'd3, 2'd2, 1'b0, 64'h7FF8_0000_0000_0ABC, 64'h7FF8_0000_0000_0ABC, 1'b0}, // R2 code 3
    {2'd0, 2'd1, 1'b0, 64'hDEAD_BEEF_0000_7E01, 64'h7FC0_2000,          1'b0}, // R2 upper ignored
    {2'd1, 2'd1, 1'b0, 64'hAAAA_5555_7FC0_0001, 64'h7FC0_0001,          1'b0}  // R2 R8
  };

  task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] sf, logic [1:0] df, logic dm, logic [63:0] w);
    @(negedge clk);
    in_valid = 1'b1; src_fmt = sf; dst_fmt = df; dflt_mode = dm; src_word = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk64("R1 reset valid", 64'(out_valid), 64'd0);
    chk64("R1 reset word", dst_word, 64'd0);
    chk64("R1 reset sticky", 64'(invalid_sticky), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][133:132], VEC[i][131:130], VEC[i][129], VEC[i][128:65]);
      chk64($sformatf("R1 valid v%0d", i), 64'(out_valid), 64'd1);
      chk64($sformatf("R5 word v%0d", i), dst_word, VEC[i][64:1]);
      chk64($sformatf("R4 invalid v%0d", i), 64'(op_invalid), 64'(VEC[i][0]));
    end

    @(negedge clk);
    chk64("R1 no strobe valid", 64'(out_valid), 64'd0);
    chk64("R1 hold word", dst_word, 64'h7FC0_0001);
    chk64("R9 sticky accumulated", 64'(invalid_sticky), 64'd1);
    flag_clear = 1'b1;
    @(negedge clk);
    flag_clear = 1'b0;
    chk64("R9 sticky cleared", 64'(invalid_sticky), 64'd0);
    @(negedge clk);
    chk64("R9 sticky stays clear", 64'(invalid_sticky), 64'd0);
    flag_clear = 1'b1;
    drive(2'd0, 2'd0, 1'b0, 64'h7C01);
    flag_clear = 1'b0;
    chk64("R9 set wins over clear", 64'(invalid_sticky), 64'd1);

    // parameter variants
    drive(2'd0, 2'd0, 1'b0, 64'h7C01);
    chk64("R3 std signaling", 64'(op_invalid), 64'd1);
    chk64("R11 inverted quiet", 64'(i_inv), 64'd0);
    chk64("R12 all quiet", 64'(i_aq), 64'd0);
    drive(2'd0, 2'd0, 1'b0, 64'h7E00);
    chk64("R3 std quiet", 64'(op_invalid), 64'd0);
    chk64("R11 inverted signaling", 64'(i_inv), 64'd1);
    drive(2'd2, 2'd2, 1'b0, 64'h7FF0_0000_0000_0001);
    chk64("R12 all quiet double", 64'(i_aq), 64'd0);
    drive(2'd0, 2'd0, 1'b1, 64'h7E12);
    chk64("R11 inverted default half", w_inv, 64'h7DFF);
    chk64("R10 negative default half", w_neg, 64'hFE00);
    chk64("R10 positive default half", dst_word, 64'h7E00);
    drive(2'd1, 2'd1, 1'b1, 64'h7FC0_0000);
    chk64("R10 negative default single", w_neg, 64'hFFC0_0000);
    chk64("R11 inverted default single", w_inv, 64'h7FBF_FFFF);
    drive(2'd1, 2'd2, 1'b1, 64'h7FC0_0000);
    chk64("R11 inverted default double", w_inv, 64'h7FF7_FFFF_FFFF_FFFF);
    chk64("R10 negative default double", w_neg, 64'hFFF8_0000_0000_0000);
    drive(2'd2, 2'd0, 1'b0, 64'h7FF0_0000_0000_0001);
    chk64("R6 R11 inverted zero payload", w_inv, 64'h7DFF);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule